// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block is a passive observer placed beside the command pins of an SDRAM controller. On every rising clock edge it decodes the sampled chip-select, row-strobe, column-strobe and write-enable lines, the bank address and the auto-precharge address bit. For every bank it maintains a model of that bank's condition: idle, opening, row open, plain read or write burst, auto-precharge read or write burst, write recovery with or without pending precharge, and precharging. It also models the device-wide refresh and mode-load intervals, each with its own countdown. It makes no change to the bus. It only judges each command.

A command that the targeted bank, or the device as a whole, may not accept at that moment produces a one-cycle `illegal` flag one clock after the edge that sampled it. The flag comes with a numeric reason and the bank at fault. A rejected command leaves every tracked state and timer exactly as it would have been without it, so one bad command does not cause a string of false reports afterwards. All timing limits are parameters counted in clock cycles, so the same monitor can follow any speed grade.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {ras_n,cas_n,we_n} with cs_n low: 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. cs_n high is a no-op. The verdict for a command sampled at edge t appears on illegal/err_code/err_bank after edge t and stays there until edge t+1. Legal commands and reset give illegal=0, err_code=0 and err_bank=0.
- R2: Mode load or refresh while any bank is not idle is rejected with code 2. err_bank names the lowest-numbered bank that is not idle.
- R3: Activate to a bank that is not idle (open, bursting, recovering or precharging) is rejected with code 3.
- R4: Read or write to a bank that is idle or precharging is rejected with code 5.
- R5: Read, write or precharge to a bank fewer than T_RCD cycles after its activate is rejected with code 6.
- R6: Activate fewer than T_RRD cycles after the previous accepted activate, to any bank, is rejected with code 4.
- R7: Precharge of an open row fewer than T_RAS cycles after its activate is rejected with code 7.
- R8: A precharged bank accepts activate again exactly T_RP cycles after the precharge.
- R9: For T_RC cycles after refresh and T_MRD cycles after mode load, any command other than no-op is rejected with code 1.
- R10: While a bank runs an auto-precharge burst (read: BURST cycles; write: BURST plus T_WR cycles), read, write, precharge, activate and burst stop to it are rejected with code 8. The bank then precharges by itself and is idle T_RP cycles later.
- R11: A plain read or write burst may be cut short by a new read or write, by a precharge or by a burst stop, all legal. A stopped write enters write recovery.
- R12: Precharge during the T_WR cycles of write recovery after a plain write burst is rejected with code 9.
- R13: A command is judged only against the bank its bank address selects. Precharge with a10 high is checked against every bank and reports the lowest failing bank.
- R14: A rejected command changes no bank or device state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select bit |
| illegal | output | 1 | One-cycle flag for a rejected command |
| err_code | output | 4 | Reason code, 0 when legal |
| err_bank | output | 2 | Bank at fault, 0 when legal |

## Verification
Two events can fall on the same edge: a bank's timer can expire (end of a burst, recovery, precharge or opening) on the very edge where a new command reaches that bank. The verdict must use the state the timer has just reached. The bench provokes this by sweeping the gap between two commands over every value from one cycle up to one past the limit, and by placing commands on the exact cycle an auto-precharge or recovery ends. For each gap it computes the expected code from the parameters alone. A second overlap is precharge-all meeting banks in different states. That case is judged by the lowest failing bank and by whether the other banks keep their state.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

  typedef enum logic [2:0] {
    C_MRS = 3'd0, C_REF = 3'd1, C_PRE = 3'd2, C_ACT = 3'd3,
    C_WR  = 3'd4, C_RD  = 3'd5, C_BST = 3'd6, C_NOP = 3'd7
  } cmd_e;

  typedef enum logic [3:0] {
    BK_IDLE, BK_OPENING, BK_OPEN, BK_RD, BK_WR, BK_RD_AP, BK_WR_AP,
    BK_WREC, BK_WREC_AP, BK_CLOSING
  } bank_st_e;

  typedef enum logic [3:0] {
    E_NONE = 4'd0, E_DEV_BUSY = 4'd1, E_ALL_IDLE = 4'd2, E_ACT_BUSY = 4'd3,
    E_RRD = 4'd4, E_NO_ROW = 4'd5, E_RCD = 4'd6, E_RAS = 4'd7,
    E_AP_LOCK = 4'd8, E_WREC = 4'd9
  } err_e;

  function automatic logic is_timed(bank_st_e s);
    return !(s == BK_IDLE || s == BK_OPEN);
  endfunction

  function automatic bank_st_e follow(bank_st_e s);
    case (s)
      BK_OPENING: return BK_OPEN;
      BK_RD:      return BK_OPEN;
      BK_WR:      return BK_WREC;
      BK_WREC:    return BK_OPEN;
      BK_RD_AP:   return BK_CLOSING;
      BK_WR_AP:   return BK_WREC_AP;
      BK_WREC_AP: return BK_CLOSING;
      BK_CLOSING: return BK_IDLE;
      default:    return s;
    endcase
  endfunction

  function automatic logic ap_locked(bank_st_e s);
    return s == BK_RD_AP || s == BK_WR_AP || s == BK_WREC_AP;
  endfunction

  function automatic logic row_open(bank_st_e s);
    return s == BK_OPEN || s == BK_RD || s == BK_WR;
  endfunction

  // Verdict for one command against one bank's present state.
  function automatic err_e bank_err(cmd_e c, bank_st_e s, logic ras_done);
    err_e e;
    e = E_NONE;
    if (ap_locked(s) && (c == C_PRE || c == C_ACT || c == C_WR ||
                         c == C_RD  || c == C_BST)) begin
      e = E_AP_LOCK;
    end else begin
      case (c)
        C_ACT: if (s != BK_IDLE) e = E_ACT_BUSY;
        C_RD, C_WR: begin
          if (s == BK_IDLE || s == BK_CLOSING) e = E_NO_ROW;
          else if (s == BK_OPENING)            e = E_RCD;
        end
        C_PRE: begin
          if (s == BK_OPENING)                 e = E_RCD;
          else if (s == BK_WREC)               e = E_WREC;
          else if (row_open(s) && !ras_done)   e = E_RAS;
        end
        default: e = E_NONE;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/sdmon_bank.sv
module sdmon_bank
  import sdmon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_WR  = 2,
  parameter int BURST = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     apply,
  input  cmd_e     cmd,
  input  logic     a10,
  output bank_st_e eff_st,
  output logic     ras_done
);
  localparam int DMAX = (T_RCD > T_RP ? T_RCD : T_RP) > (T_WR > BURST ? T_WR : BURST)
                      ? (T_RCD > T_RP ? T_RCD : T_RP) : (T_WR > BURST ? T_WR : BURST);
  localparam int CW = $clog2(DMAX + 1);
  localparam int RW = $clog2(T_RAS + 1);

  bank_st_e        st, nst;
  logic [CW-1:0]   cnt, ncnt;
  logic [RW-1:0]   rcnt;
  logic            expiring;

  function automatic logic [CW-1:0] hold_of(bank_st_e s);
    case (s)
      BK_OPENING:                        return CW'(T_RCD - 1);
      BK_RD, BK_WR, BK_RD_AP, BK_WR_AP:  return CW'(BURST - 1);
      BK_WREC, BK_WREC_AP:               return CW'(T_WR - 1);
      BK_CLOSING:                        return CW'(T_RP - 1);
      default:                           return '0;
    endcase
  endfunction

  // A timed state whose count is spent is already its successor this cycle.
  assign expiring = is_timed(st) && (cnt == '0);
  assign eff_st   = expiring ? follow(st) : st;
  assign ras_done = (rcnt == '0);

  always_comb begin
    nst  = st;
    ncnt = cnt;
    if (expiring) begin
      nst  = follow(st);
      ncnt = hold_of(nst);
    end else if (cnt != '0) begin
      ncnt = cnt - 1'b1;
    end
    if (apply) begin
      case (cmd)
        C_ACT: begin nst = BK_OPENING; ncnt = hold_of(nst); end
        C_RD:  begin nst = a10 ? BK_RD_AP : BK_RD; ncnt = hold_of(nst); end
        C_WR:  begin nst = a10 ? BK_WR_AP : BK_WR; ncnt = hold_of(nst); end
        C_PRE: if (row_open(eff_st)) begin nst = BK_CLOSING; ncnt = hold_of(nst); end
        C_BST: begin
          if (eff_st == BK_RD) begin nst = BK_OPEN; ncnt = '0; end
          else if (eff_st == BK_WR) begin nst = BK_WREC; ncnt = hold_of(nst); end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= BK_IDLE;
      cnt  <= '0;
      rcnt <= '0;
    end else begin
      st  <= nst;
      cnt <= ncnt;
      if (apply && cmd == C_ACT)  rcnt <= RW'(T_RAS - 1);
      else if (rcnt != '0)        rcnt <= rcnt - 1'b1;
    end
  end

  // R3
  act_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd == C_ACT) |-> (eff_st == BK_IDLE));

  // R7
  ras_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd == C_PRE && row_open(eff_st)) |-> ras_done);

  // R10
  ap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_locked(eff_st) |-> !apply);

endmodule

// File: rtl/sdmon_device.sv
module sdmon_device
  import sdmon_pkg::*;
#(
  parameter int T_RC  = 8,
  parameter int T_MRD = 2,
  parameter int T_RRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic accept,
  output logic busy,
  output logic rrd_ok
);
  localparam int DW  = $clog2((T_RC > T_MRD ? T_RC : T_MRD) + 1);
  localparam int RRW = $clog2(T_RRD + 1);

  typedef enum logic [1:0] {D_IDLE, D_REF, D_MRS} dev_st_e;

  dev_st_e        dst;
  logic [DW-1:0]  dcnt;
  logic [RRW-1:0] rrd_cnt;

  assign busy   = (dst != D_IDLE) && (dcnt != '0);
  assign rrd_ok = (rrd_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst     <= D_IDLE;
      dcnt    <= '0;
      rrd_cnt <= '0;
    end else begin
      if (accept && cmd == C_REF) begin
        dst  <= D_REF;
        dcnt <= DW'(T_RC - 1);
      end else if (accept && cmd == C_MRS) begin
        dst  <= D_MRS;
        dcnt <= DW'(T_MRD - 1);
      end else if (dst != D_IDLE && dcnt == '0) begin
        dst <= D_IDLE;
      end else if (dcnt != '0) begin
        dcnt <= dcnt - 1'b1;
      end
      if (accept && cmd == C_ACT)  rrd_cnt <= RRW'(T_RRD - 1);
      else if (rrd_cnt != '0)      rrd_cnt <= rrd_cnt - 1'b1;
    end
  end

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R6
  rrd_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == C_ACT) |-> rrd_ok);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdmon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST     = 4,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            illegal,
  output logic [3:0]      err_code,
  output logic [BA_W-1:0] err_bank
);
  cmd_e                 cmd;
  bank_st_e             eff_st [NUM_BANKS];
  logic [NUM_BANKS-1:0] ras_done;
  logic [NUM_BANKS-1:0] apply;
  err_e                 verdict;
  logic [BA_W-1:0]      vbank;
  logic                 accept;
  logic                 dev_busy;
  logic                 rrd_ok;
  logic                 pre_all;

  assign cmd     = cs_n ? C_NOP : cmd_e'({ras_n, cas_n, we_n});
  assign pre_all = (cmd == C_PRE) && a10;

  always_comb begin
    verdict = E_NONE;
    vbank   = ba;
    if (cmd != C_NOP) begin
      if (dev_busy) begin
        verdict = E_DEV_BUSY;
      end else if (cmd == C_MRS || cmd == C_REF) begin
        for (int i = 0; i < NUM_BANKS; i++) begin
          if (verdict == E_NONE && eff_st[i] != BK_IDLE) begin
            verdict = E_ALL_IDLE;
            vbank   = BA_W'(i);
          end
        end
      end else if (pre_all) begin
        for (int i = 0; i < NUM_BANKS; i++) begin
          if (verdict == E_NONE && bank_err(C_PRE, eff_st[i], ras_done[i]) != E_NONE) begin
            verdict = bank_err(C_PRE, eff_st[i], ras_done[i]);
            vbank   = BA_W'(i);
          end
        end
      end else begin
        verdict = bank_err(cmd, eff_st[ba], ras_done[ba]);
        if (verdict == E_NONE && cmd == C_ACT && !rrd_ok) verdict = E_RRD;
      end
    end
  end

  assign accept = (cmd != C_NOP) && (verdict == E_NONE);

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign apply[g] = accept && (pre_all ||
                        ((ba == BA_W'(g)) && cmd != C_MRS && cmd != C_REF));
      sdmon_bank #(
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR), .BURST(BURST)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply[g]),
        .cmd      (cmd),
        .a10      (a10),
        .eff_st   (eff_st[g]),
        .ras_done (ras_done[g])
      );
    end
  endgenerate

  sdmon_device #(.T_RC(T_RC), .T_MRD(T_MRD), .T_RRD(T_RRD)) u_dev (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .accept (accept),
    .busy   (dev_busy),
    .rrd_ok (rrd_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal  <= 1'b0;
      err_code <= 4'd0;
      err_bank <= '0;
    end else begin
      illegal  <= (verdict != E_NONE);
      err_code <= verdict;
      err_bank <= (verdict != E_NONE) ? vbank : '0;
    end
  end

  // R1
  code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (err_code == 4'd0 && err_bank == '0));

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (err_code >= 4'd1 && err_code <= 4'd9));

  // R13
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pre_all) |-> $onehot0(apply));

endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int T_RCD = 3, T_RRD = 2, T_RAS = 6, T_RP = 3;
  localparam int T_RC = 8, T_MRD = 2, T_WR = 2, BURST = 4;

  localparam logic [2:0] MRS = 3'd0, REF = 3'd1, PRE = 3'd2, ACT = 3'd3;
  localparam logic [2:0] WR = 3'd4, RD = 3'd5, BST = 3'd6, NOP = 3'd7;
  localparam logic [3:0] OK = 4'd0, DEVB = 4'd1, NIDL = 4'd2, ACTB = 4'd3, RRD = 4'd4;
  localparam logic [3:0] NOROW = 4'd5, RCD = 4'd6, RAS = 4'd7, APL = 4'd8, WREC = 4'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic illegal;
  logic [3:0] err_code;
  logic [1:0] err_bank;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_monitor #(
    .NUM_BANKS(4), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .T_WR(T_WR), .BURST(BURST)
  ) i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .illegal(illegal), .err_code(err_code),
    .err_bank(err_bank)
  );

  task automatic check(input logic [3:0] ec, input int eb, input string tag);
    checks++;
    if (illegal !== (ec != 4'd0) || err_code !== ec || err_bank !== 2'(eb)) begin
      fails++;
      $display("FAIL %s: got illegal=%0b code=%0d bank=%0d, expected illegal=%0b code=%0d bank=%0d",
               tag, illegal, err_code, err_bank, (ec != 4'd0), ec, eb);
    end
  endtask

  // Drives one command for the coming edge; checks the verdict after it.
  task automatic issue(input logic [2:0] c, input int b, input logic a,
                       input logic [3:0] ec, input int eb, input string tag);
    cs_n = (c == NOP);
    {ras_n, cas_n, we_n} = c;
    ba = 2'(b);
    a10 = a;
    @(negedge clk);
    check(ec, (ec == 4'd0) ? 0 : eb, tag);
    cs_n = 1'b1;
  endtask

  task automatic nops(input int n);
    cs_n = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no finish, expected run to end");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(OK, 0, "R1 reset state");

    // R4: read/write to idle banks
    for (int b = 0; b < 4; b++) begin
      issue(RD, b, 1'b0, NOROW, b, "R4 read idle bank");
      issue(WR, b, 1'b0, NOROW, b, "R4 write idle bank");
    end
    issue(NOP, 0, 1'b0, OK, 0, "R1 flag is one cycle");

    // R3: activate to open bank, R4 read to precharging bank
    issue(ACT, 1, 1'b0, OK, 1, "R3 first activate");
    nops(T_RAS);
    issue(ACT, 1, 1'b0, ACTB, 1, "R3 activate open bank");
    issue(PRE, 1, 1'b0, OK, 1, "R3 precharge");
    issue(RD, 1, 1'b0, NOROW, 1, "R4 read precharging bank");
    nops(T_RP);

    // R5: tRCD sweep
    for (int k = 1; k <= T_RCD + 1; k++) begin
      issue(ACT, 0, 1'b0, OK, 0, "R5 activate");
      nops(k - 1);
      issue(RD, 0, 1'b0, (k < T_RCD) ? RCD : OK, 0, "R5 read after activate");
      nops(T_RAS + BURST);
      issue(PRE, 0, 1'b0, OK, 0, "R5 close");
      nops(T_RP);
    end

    // R6: tRRD sweep across banks
    for (int k = 1; k <= T_RRD + 1; k++) begin
      issue(ACT, 0, 1'b0, OK, 0, "R6 activate first");
      nops(k - 1);
      issue(ACT, 1, 1'b0, (k < T_RRD) ? RRD : OK, 1, "R6 activate second bank");
      nops(T_RAS);
      issue(PRE, 0, 1'b1, OK, 0, "R6 precharge all");
      nops(T_RP);
    end

    // R7: tRAS sweep (early cycles still opening give R5 code)
    for (int k = 1; k <= T_RAS + 1; k++) begin
      issue(ACT, 2, 1'b0, OK, 2, "R7 activate");
      nops(k - 1);
      issue(PRE, 2, 1'b0, (k < T_RCD) ? RCD : (k < T_RAS) ? RAS : OK, 2, "R7 precharge timing");
      nops(T_RAS + T_RP + 1);
      issue(PRE, 2, 1'b0, OK, 2, "R7 late precharge");
      nops(T_RP);
    end

    // R8: tRP sweep
    for (int k = 1; k <= T_RP + 1; k++) begin
      issue(ACT, 3, 1'b0, OK, 3, "R8 activate");
      nops(T_RAS - 1);
      issue(PRE, 3, 1'b0, OK, 3, "R8 precharge");
      nops(k - 1);
      issue(ACT, 3, 1'b0, (k < T_RP) ? ACTB : OK, 3, "R8 reactivate after precharge");
      nops(T_RP + T_RAS);
      issue(PRE, 3, 1'b0, OK, 3, "R8 close");
      nops(T_RP);
    end

    // R2 and R14: refresh / mode load need all banks idle
    issue(ACT, 1, 1'b0, OK, 1, "R2 open bank");
    nops(T_RCD);
    issue(REF, 0, 1'b0, NIDL, 1, "R2 refresh with open bank");
    issue(MRS, 0, 1'b0, NIDL, 1, "R2 mode load with open bank");
    issue(RD, 1, 1'b0, OK, 1, "R14 rejected refresh left device free");
    nops(T_RAS + BURST);
    issue(PRE, 1, 1'b0, OK, 1, "R2 close");
    nops(T_RP);

    // R9: device busy after refresh / mode load
    for (int k = 1; k <= T_RC + 1; k++) begin
      issue(REF, 0, 1'b0, OK, 0, "R9 refresh");
      nops(k - 1);
      issue(ACT, 0, 1'b0, (k < T_RC) ? DEVB : OK, 0, "R9 activate after refresh");
      nops(T_RC + T_RAS);
      issue(PRE, 0, 1'b0, OK, 0, "R9 close");
      nops(T_RP);
    end
    for (int k = 1; k <= T_MRD + 1; k++) begin
      issue(MRS, 0, 1'b0, OK, 0, "R9 mode load");
      nops(k - 1);
      issue(ACT, 2, 1'b0, (k < T_MRD) ? DEVB : OK, 2, "R9 activate after mode load");
      nops(T_MRD + T_RAS);
      issue(PRE, 2, 1'b0, OK, 2, "R9 close");
      nops(T_RP);
    end

    // R10/R13: read with auto-precharge, other bank stays usable
    issue(ACT, 0, 1'b0, OK, 0, "R10 open");
    nops(T_RCD - 1);
    issue(RD, 0, 1'b1, OK, 0, "R10 read auto-precharge");
    issue(ACT, 1, 1'b0, OK, 1, "R13 other bank activate during lock");
    issue(BST, 0, 1'b0, APL, 0, "R10 burst stop locked");
    issue(PRE, 0, 1'b0, APL, 0, "R10 precharge locked");
    nops(BURST + T_RP - 5);
    issue(ACT, 0, 1'b0, ACTB, 0, "R10 activate one cycle early");
    issue(ACT, 0, 1'b0, OK, 0, "R10 activate after auto precharge");
    nops(T_RAS);
    issue(PRE, 0, 1'b1, OK, 0, "R10 close all");
    nops(T_RP);

    // R10: write with auto-precharge
    issue(ACT, 2, 1'b0, OK, 2, "R10 open for write");
    nops(T_RCD - 1);
    issue(WR, 2, 1'b1, OK, 2, "R10 write auto-precharge");
    issue(RD, 2, 1'b0, APL, 2, "R10 read locked");
    issue(WR, 2, 1'b0, APL, 2, "R10 write locked");
    issue(ACT, 2, 1'b0, APL, 2, "R10 activate locked");
    nops(BURST + T_WR + T_RP - 5);
    issue(ACT, 2, 1'b0, ACTB, 2, "R10 write-ap activate early");
    issue(ACT, 2, 1'b0, OK, 2, "R10 write-ap activate on time");
    nops(T_RAS);
    issue(PRE, 2, 1'b0, OK, 2, "R10 close");
    nops(T_RP);

    // R11: plain bursts interrupted
    issue(ACT, 2, 1'b0, OK, 2, "R11 open");
    nops(T_RCD - 1);
    issue(RD, 2, 1'b0, OK, 2, "R11 read");
    issue(RD, 2, 1'b0, OK, 2, "R11 read interrupts read");
    issue(WR, 2, 1'b0, OK, 2, "R11 write interrupts read");
    issue(PRE, 2, 1'b0, OK, 2, "R11 precharge interrupts write");
    nops(T_RP - 2);
    issue(ACT, 2, 1'b0, ACTB, 2, "R11 still precharging");
    issue(ACT, 2, 1'b0, OK, 2, "R11 reopen");
    nops(T_RCD - 1);
    issue(RD, 2, 1'b0, OK, 2, "R11 read before stop");
    issue(BST, 2, 1'b0, OK, 2, "R11 burst stop");
    issue(RD, 2, 1'b0, OK, 2, "R11 read after stop");
    nops(T_RAS + BURST);
    issue(PRE, 2, 1'b0, OK, 2, "R11 close");
    nops(T_RP);

    // R12: write recovery window
    issue(ACT, 3, 1'b0, OK, 3, "R12 open");
    nops(T_RAS);
    issue(WR, 3, 1'b0, OK, 3, "R12 write");
    nops(BURST - 1);
    for (int k = 0; k <= T_WR; k++)
      issue(PRE, 3, 1'b0, (k < T_WR) ? WREC : OK, 3, "R12 precharge vs recovery");
    nops(T_RP);

    // R13: precharge-all reports lowest failing bank
    issue(ACT, 0, 1'b0, OK, 0, "R13 open bank 0");
    nops(T_RAS);
    issue(ACT, 1, 1'b0, OK, 1, "R13 open bank 1");
    nops(T_RCD - 1);
    issue(PRE, 0, 1'b1, RAS, 1, "R13 precharge all with young row");
    issue(RD, 0, 1'b0, OK, 0, "R14 bank 0 still open after rejected precharge");
    nops(T_RAS + BURST);
    issue(PRE, 2, 1'b1, OK, 0, "R13 precharge all");
    nops(T_RP);
    issue(RD, 0, 1'b0, NOROW, 0, "R13 bank 0 closed");
    issue(RD, 1, 1'b0, NOROW, 1, "R13 bank 1 closed");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule